// File: doc/BRIEF.md
# Rank Multiplication Decision Unit

This unit takes the raw geometry fields that describe one buffered memory module and works out how that module's physical ranks are folded onto the chip selects that the controller drives. It decodes the physical rank count. From that count, the number of module slots on the channel and the device density, it chooses a rank multiplier. It then derives the logical rank count the controller sees, the widened row-address width, a two-bit rank-definition code, and a mask of chip selects that must be withdrawn because their lines are reused as extra row-address bits.

A single-cycle start pulse samples the input fields. One clock later the results appear on registered outputs together with a one-cycle valid pulse. The results hold until the next start. A rank code with no defined meaning raises an error flag and returns neutral results. Fetching the fields and applying the results to a controller are both done elsewhere.

Top module: `rank_mult_unit`

## Requirements
- R1: While reset is low and after it is released, all outputs are zero until the first start pulse.
- R2: A start pulse in one cycle gives valid_o high for exactly the following cycle; without start, every result output holds its value.
- R3: The physical rank count is rank_code + 1 for codes 0 to 3, and code 4 means 8 ranks.
- R4: Rank codes 5, 6 and 7 set err_o, with multiplier, logical ranks, rank-definition and chip-select mask all zero.
- R5: A physical rank count below 4 gives multiplier 1.
- R6: With exactly 4 ranks, the multiplier is 1 when slot_count is below 3, and 2 otherwise.
- R7: With 8 ranks, the multiplier is 2 when slot_count is below 3 and dens_code is below 4, and 4 otherwise.
- R8: The logical rank count equals the physical rank count divided by the multiplier.
- R9: The row-address width equals 12 + row_code + (multiplier / 2).
- R10: rank_def_o is 3 for multiplier 4, and otherwise equals the multiplier.
- R11: When the row-address width exceeds 16, cs_clear_o has bits 4 and 5 set, shifted left by 1 if slot_count exceeds 2 and by module_idx otherwise, with bits past NUM_CS-1 dropped; otherwise it is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Sample the fields and compute |
| rank_code | input | 3 | Encoded physical rank count |
| dens_code | input | 4 | Device density code |
| row_code | input | 3 | Row-address width code (width minus 12) |
| slot_count | input | SLOT_W (2) | Number of module slots on the channel |
| module_idx | input | IDX_W (2) | Index of this module on the channel |
| mult_o | output | 3 | Rank multiplier (1, 2, 4; 0 on error) |
| log_ranks_o | output | 4 | Logical rank count |
| row_bits_o | output | 5 | Effective row-address width |
| rank_def_o | output | 2 | Rank-definition code |
| cs_clear_o | output | NUM_CS (8) | Chip selects to withdraw |
| valid_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | Unsupported rank code |

## Verification
The assertions watch on every cycle that the valid strobe follows start and that the results hold between starts. They also check that a legal result has a single-bit multiplier, that the multiplier times the logical count equals the decoded physical count, that the rank-definition code tracks a multiplier of 4, and that chip selects are withdrawn only for widths above 16. The exact multiplier choice at the slot and density thresholds, the row-width boundary at 16, and the shift position of the mask, including truncation at the top chip select, are shown only by the bench's directed scenarios.

// File: rtl/rank_mult_pkg.sv
package rank_mult_pkg;
  localparam int RANK_W = 4;
  localparam int MULT_W = 3;
  localparam int ROW_W  = 5;
  localparam int DEF_W  = 2;

  // Physical rank count from its code; 0 marks an undefined code.
  function automatic logic [RANK_W-1:0] decode_ranks(input logic [2:0] code);
    if (code <= 3'd3) return {1'b0, code} + 4'd1;
    else if (code == 3'd4) return 4'd8;
    else return 4'd0;
  endfunction

  function automatic logic [MULT_W-1:0] choose_mult(input logic [RANK_W-1:0] ranks,
                                                    input logic many_slots,
                                                    input logic low_dens);
    if (ranks < 4'd4) return 3'd1;
    else if (ranks == 4'd4) return many_slots ? 3'd2 : 3'd1;
    else return (!many_slots && low_dens) ? 3'd2 : 3'd4;
  endfunction

  // Multiplier halved is also the shift that divides by it.
  function automatic logic [ROW_W-1:0] row_width(input logic [2:0] rc,
                                                 input logic [MULT_W-1:0] m);
    return 5'd12 + {2'b00, rc} + {3'b000, m[2:1]};
  endfunction

  function automatic logic [DEF_W-1:0] def_code(input logic [MULT_W-1:0] m);
    return (m == 3'd4) ? 2'd3 : m[1:0];
  endfunction
endpackage

// File: rtl/rm_rank_decode.sv
module rm_rank_decode
  import rank_mult_pkg::*;
(
  input  logic [2:0]        rank_code,
  output logic [RANK_W-1:0] phys_ranks,
  output logic              unsupported
);
  always_comb begin
    phys_ranks  = decode_ranks(rank_code);
    unsupported = (rank_code > 3'd4);
  end
endmodule

// File: rtl/rm_mult_select.sv
module rm_mult_select
  import rank_mult_pkg::*;
#(
  parameter int SLOT_W = 2
) (
  input  logic [RANK_W-1:0] phys_ranks,
  input  logic              unsupported,
  input  logic [3:0]        dens_code,
  input  logic [SLOT_W-1:0] slot_count,
  output logic [MULT_W-1:0] mult,
  output logic [RANK_W-1:0] log_ranks,
  output logic [DEF_W-1:0]  rank_def
);
  logic many_slots;
  logic low_dens;

  always_comb begin
    many_slots = (int'(slot_count) >= 3);
    low_dens   = (dens_code < 4'd4);
    if (unsupported) begin
      mult      = '0;
      log_ranks = '0;
      rank_def  = '0;
    end else begin
      mult      = choose_mult(phys_ranks, many_slots, low_dens);
      log_ranks = phys_ranks >> mult[2:1];
      rank_def  = def_code(mult);
    end
  end
endmodule

// File: rtl/rm_cs_release.sv
module rm_cs_release
  import rank_mult_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int SLOT_W = 2,
  parameter int IDX_W  = 2
) (
  input  logic [ROW_W-1:0]  row_bits,
  input  logic              unsupported,
  input  logic [SLOT_W-1:0] slot_count,
  input  logic [IDX_W-1:0]  module_idx,
  output logic [NUM_CS-1:0] cs_clear
);
  logic wide_rows;
  int   shamt;

  always_comb begin
    wide_rows = !unsupported && (row_bits > 5'd16);
    shamt     = (int'(slot_count) > 2) ? 1 : int'(module_idx);
  end

  // Base pattern occupies chip selects 4 and 5 before the shift.
  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_clear[g] = wide_rows && ((g == shamt + 4) || (g == shamt + 5));
  end
endmodule

// File: rtl/rank_mult_unit.sv
module rank_mult_unit
  import rank_mult_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int SLOT_W = 2,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        rank_code,
  input  logic [3:0]        dens_code,
  input  logic [2:0]        row_code,
  input  logic [SLOT_W-1:0] slot_count,
  input  logic [IDX_W-1:0]  module_idx,
  output logic [2:0]        mult_o,
  output logic [3:0]        log_ranks_o,
  output logic [4:0]        row_bits_o,
  output logic [1:0]        rank_def_o,
  output logic [NUM_CS-1:0] cs_clear_o,
  output logic              valid_o,
  output logic              err_o
);
  logic [RANK_W-1:0] phys_w;
  logic              unsup_w;
  logic [MULT_W-1:0] mult_w;
  logic [RANK_W-1:0] log_w;
  logic [DEF_W-1:0]  def_w;
  logic [ROW_W-1:0]  row_w;
  logic [NUM_CS-1:0] clear_w;

  rm_rank_decode i_decode (
    .rank_code  (rank_code),
    .phys_ranks (phys_w),
    .unsupported(unsup_w)
  );

  rm_mult_select #(.SLOT_W(SLOT_W)) i_select (
    .phys_ranks (phys_w),
    .unsupported(unsup_w),
    .dens_code  (dens_code),
    .slot_count (slot_count),
    .mult       (mult_w),
    .log_ranks  (log_w),
    .rank_def   (def_w)
  );

  assign row_w = row_width(row_code, mult_w);

  rm_cs_release #(.NUM_CS(NUM_CS), .SLOT_W(SLOT_W), .IDX_W(IDX_W)) i_release (
    .row_bits   (row_w),
    .unsupported(unsup_w),
    .slot_count (slot_count),
    .module_idx (module_idx),
    .cs_clear   (clear_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mult_o      <= '0;
      log_ranks_o <= '0;
      row_bits_o  <= '0;
      rank_def_o  <= '0;
      cs_clear_o  <= '0;
      valid_o     <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      valid_o <= start;
      if (start) begin
        mult_o      <= mult_w;
        log_ranks_o <= log_w;
        row_bits_o  <= row_w;
        rank_def_o  <= def_w;
        cs_clear_o  <= clear_w;
        err_o       <= unsup_w;
      end
    end
  end

  a_r2_valid_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> valid_o);
  a_r2_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(mult_o) && $stable(cs_clear_o) && $stable(row_bits_o)));
  a_r4_error_neutral: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (mult_o == 3'd0 && cs_clear_o == '0 && log_ranks_o == 4'd0));
  a_r5_single_bit_mult: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !err_o) |-> ($countones(mult_o) == 1));
  a_r8_product_matches: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !unsup_w) |-> ((log_w * mult_w) == {3'b000, phys_w}));
  a_r10_def_tracks_four: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !err_o) |-> ((rank_def_o == 2'd3) == (mult_o == 3'd4)));
  a_r11_clear_needs_width: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_clear_o != '0) |-> (row_bits_o > 5'd16));
endmodule

// File: tb/test_rank_mult_unit.sv
module test_rank_mult_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] rank_code = '0;
  logic [3:0] dens_code = '0;
  logic [2:0] row_code = '0;
  logic [1:0] slot_count = '0;
  logic [1:0] module_idx = '0;
  logic [2:0] mult_o;
  logic [3:0] log_ranks_o;
  logic [4:0] row_bits_o;
  logic [1:0] rank_def_o;
  logic [NUM_CS-1:0] cs_clear_o;
  logic valid_o, err_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rank_mult_unit i_rank_mult_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .rank_code(rank_code),
    .dens_code(dens_code), .row_code(row_code), .slot_count(slot_count),
    .module_idx(module_idx), .mult_o(mult_o), .log_ranks_o(log_ranks_o),
    .row_bits_o(row_bits_o), .rank_def_o(rank_def_o), .cs_clear_o(cs_clear_o),
    .valid_o(valid_o), .err_o(err_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One scenario: drive fields, pulse start, compare against values worked out here.
  task automatic scenario(input int rc, input int dc, input int wc, input int sc, input int ix);
    int ph, m, lg, rw, df, mk;
    bit bad;
    bad = (rc > 4);
    ph = (rc == 4) ? 8 : rc + 1;                                // R3
    if (bad) m = 0;
    else if (ph < 4) m = 1;                                      // R5
    else if (ph == 4) m = (sc < 3) ? 1 : 2;                      // R6
    else m = (sc < 3 && dc < 4) ? 2 : 4;                         // R7
    lg = bad ? 0 : ph / m;                                       // R8
    rw = 12 + wc + m / 2;                                        // R9
    df = (m == 4) ? 3 : m;                                       // R10
    mk = (!bad && rw > 16) ? ((48 << ((sc > 2) ? 1 : ix)) & 255) : 0; // R11
    @(negedge clk);
    rank_code = 3'(rc); dens_code = 4'(dc); row_code = 3'(wc);
    slot_count = 2'(sc); module_idx = 2'(ix); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 valid", int'(valid_o), 1);
    check("R4 err", int'(err_o), int'(bad));
    check(bad ? "R4 mult" : "R5/R6/R7 mult", int'(mult_o), m);
    check("R8 logical", int'(log_ranks_o), lg);
    check("R9 rowbits", int'(row_bits_o), rw);
    check("R10 rankdef", int'(rank_def_o), bad ? 0 : df);
    check("R11 csclear", int'(cs_clear_o), mk);
    // Change fields without start: results must hold, valid must drop.
    rank_code = 3'd1; row_code = 3'd0; slot_count = 2'd0;
    @(negedge clk);
    check("R2 valid drop", int'(valid_o), 0);
    check("R2 hold mult", int'(mult_o), m);
    check("R2 hold csclear", int'(cs_clear_o), mk);
  endtask

  task automatic reset_check();
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(valid_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 mult", int'(mult_o), 0);
    check("R1 csclear", int'(cs_clear_o), 0);
    check("R1 err", int'(err_o), 0);
    check("R1 valid", int'(valid_o), 0);
  endtask

  initial begin
    reset_check();
    scenario(0, 2, 4, 2, 0);  // R3 R5: 1 rank, width exactly 16, no release
    scenario(2, 3, 2, 1, 1);  // R3 R8: 3 ranks
    scenario(3, 3, 5, 2, 0);  // R6: 4 ranks, 2 slots -> 1
    scenario(3, 3, 5, 3, 0);  // R6 R11: 4 ranks, 3 slots -> 2, width 18
    scenario(4, 3, 3, 2, 0);  // R7: low density, width 16 boundary
    scenario(4, 4, 3, 2, 1);  // R7 R10: density 4 -> 4, mask shifted by index
    scenario(4, 2, 3, 3, 0);  // R7 R11: 3 slots -> 4, shift 1
    scenario(4, 5, 7, 2, 3);  // R11: shift by 3, top bit dropped
    scenario(5, 2, 7, 3, 0);  // R4
    scenario(7, 2, 6, 2, 1);  // R4
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule